// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is a slave-only I2C port for a few configuration registers. The host can write two 6-bit registers, A and B. It can read A, B and a snapshot of a 5-bit input port. SCL and SDA are oversampled by the system clock. Both lines go through a two-flop synchronizer, and bus conditions are decoded from the synchronized copies. The block never drives SCL. It pulls SDA low through an open-drain enable.

A write transaction is an address byte followed by a data byte. Bits 7:6 of the data byte select the target register and bits 5:0 hold the new value. A read transaction always starts at register A. It then returns B, then the input snapshot, and wraps to A for as long as the master keeps acknowledging. The slave address is chosen by a single strap input that selects between two fixed 7-bit values.

Top module: `i2c_cfg_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Both are judged on the synchronized lines. A STOP aborts any transfer in progress and releases SDA. The slave never asserts its SDA enable while the synchronized SCL is high, and it never drives SDA while the master is sending bits.
- R2: The slave acknowledges (drives ACK low) only address 7'b1001110 when `addr_sel_i`=1, and only 7'b0110111 when it is 0. After any other address it stays released until the next START.
- R3: The general call address 7'b0000000 is never acknowledged, and the bytes that follow it have no effect.
- R4: After a read address, the returned bytes are register A, then register B, then the input snapshot. Each further byte needs an ACK from the master.
- R5: In a write, the byte after the address is acknowledged. If its bits 7:6 are 2'b00, bits 5:0 are loaded into register A. If they are 2'b01, bits 5:0 are loaded into register B. Both registers reset to 0.
- R6: Read bytes carry 2'b00 in bits 7:6, and they are sent MSB first. Registers A and B appear in bits 5:0. The input-port byte holds in bits 4:0 the value of `in_port_i` sampled in the cycle the START is detected.
- R7: A repeated START with no STOP in between begins a new transaction, and a write issued that way takes effect.
- R8: Reads do not change any register, and a read may be cut short by a STOP after any byte.
- R9: While `wp_i`=1, write data bytes are acknowledged but no register changes.
- R10: A write byte whose bits 7:6 are 2'b1x is acknowledged, and neither register changes.
- R11: After the master NACKs a read byte, the slave releases SDA and stays released until the next START or STOP.
- R12: If the master acknowledges the input-port byte, the next read byte is register A again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 1 | Strap selecting one of two slave addresses |
| wp_i | input | 1 | Write protect, 1 blocks register updates |
| in_port_i | input | 5 | Parallel input captured at START |
| reg_a_o | output | 6 | Configuration register A |
| reg_b_o | output | 6 | Configuration register B |

## Verification
Two functions can fall in the same system clock cycle: capturing the input port and detecting a START. The bench changes `in_port_i` in the same cycle as the master pulls SDA low for a START. Because of the synchronizer delay, the new value must be the one captured. A later change made after the START must not show up in the input byte. A reference model in the bench also checks both register outputs on every clock, and checks that SDA is released whenever the master owns a data bit. This way an ignored write or a protected write can never leak into a register between the explicit checks.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } eng_st_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR_HI = 7'b1001110,
  parameter logic [6:0] ADDR_LO = 7'b0110111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              sda_oe_o
);
  eng_st_e           st_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              is_addr_q, rd_q, oe_q;
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [6:0]        own_addr;
  logic              addr_hit, byte_end;

  assign own_addr = addr_sel_i ? ADDR_HI : ADDR_LO;
  assign addr_hit = (sh_q[7:1] == own_addr);
  assign byte_end = (st_q == ST_RX) && scl_fall_i && (bit_q == CNT_W'(8));
  assign idx_nxt  = (idx_q == IDX_W'(2)) ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      is_addr_q <= 1'b1;
      rd_q      <= 1'b0;
      oe_q      <= 1'b0;
      idx_q     <= '0;
    end else if (start_i) begin
      st_q      <= ST_RX;
      bit_q     <= '0;
      is_addr_q <= 1'b1;
      oe_q      <= 1'b0;
      idx_q     <= '0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise_i && bit_q < CNT_W'(8)) begin
            sh_q  <= {sh_q[6:0], sda_i};
            bit_q <= bit_q + CNT_W'(1);
          end else if (byte_end) begin
            if (!is_addr_q || addr_hit) begin
              st_q <= ST_ACK;
              oe_q <= 1'b1;
              if (is_addr_q) rd_q <= sh_q[0];
            end else begin
              st_q <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_q <= '0;
            if (rd_q) begin
              st_q <= ST_TX;
              sh_q <= tx_byte_i;
              oe_q <= ~tx_byte_i[7];
            end else begin
              st_q      <= ST_RX;
              is_addr_q <= 1'b0;
              oe_q      <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            bit_q <= bit_q + CNT_W'(1);
            if (bit_q == CNT_W'(7)) begin
              st_q <= ST_RACK;
              oe_q <= 1'b0;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0};
              oe_q <= ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          // advance on the master's ACK so the next byte is ready at SCL fall
          if (scl_rise_i) begin
            rd_q <= ~sda_i;
            if (!sda_i) idx_q <= idx_nxt;
          end else if (scl_fall_i) begin
            bit_q <= '0;
            if (rd_q) begin
              st_q <= ST_TX;
              sh_q <= tx_byte_i;
              oe_q <= ~tx_byte_i[7];
            end else begin
              st_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = byte_end && !is_addr_q && !start_i && !stop_i;
  assign wr_byte_o = sh_q;
  assign rd_idx_o  = idx_q;
  assign sda_oe_o  = oe_q;

  // R1
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  // R1
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  // R3
  no_gcall_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && is_addr_q && !start_i && !stop_i && sh_q[7:1] == 7'd0) |=> !sda_oe_o);
  // R6
  top_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX && bit_q < CNT_W'(2)) |-> sda_oe_o);
  // R11
  wait_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !sda_oe_o);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int               REG_W = 6,
  parameter int               IN_W  = 5,
  parameter logic [REG_W-1:0] RST_A = '0,
  parameter logic [REG_W-1:0] RST_B = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              wp_i,
  input  logic              cap_i,
  input  logic [IN_W-1:0]   in_port_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [REG_W-1:0]  reg_a_o,
  output logic [REG_W-1:0]  reg_b_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  localparam int                     N_WR    = 2;
  localparam logic [N_WR*REG_W-1:0]  RST_VAL = {RST_B, RST_A};

  logic [N_WR-1:0][REG_W-1:0] regs;
  logic [IN_W-1:0]            snap_q;

  for (genvar g = 0; g < N_WR; g++) begin : g_reg
    logic [REG_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= RST_VAL[g*REG_W +: REG_W];
      else if (wr_en_i && !wp_i && wr_byte_i[BYTE_W-1 -: SEL_W] == SEL_W'(g))
        val_q <= wr_byte_i[REG_W-1:0];
    end
    assign regs[g] = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (cap_i) snap_q <= in_port_i;
  end

  always_comb begin
    unique case (rd_idx_i)
      IDX_W'(0): rd_byte_o = BYTE_W'(regs[0]);
      IDX_W'(1): rd_byte_o = BYTE_W'(regs[1]);
      IDX_W'(2): rd_byte_o = BYTE_W'(snap_q);
      default:   rd_byte_o = '0;
    endcase
  end

  assign reg_a_o = regs[0];
  assign reg_b_o = regs[1];

  // R9
  wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wp_i) |-> $stable(regs));
  // R10
  sel_hi_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_byte_i[BYTE_W-1]) |=> $stable(regs));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int               REG_W   = 6,
  parameter int               IN_W    = 5,
  parameter int               STAGES  = 2,
  parameter logic [6:0]       ADDR_HI = 7'b1001110,
  parameter logic [6:0]       ADDR_LO = 7'b0110111,
  parameter logic [REG_W-1:0] RST_A   = '0,
  parameter logic [REG_W-1:0] RST_B   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             addr_sel_i,
  input  logic             wp_i,
  input  logic [IN_W-1:0]  in_port_i,
  output logic [REG_W-1:0] reg_a_o,
  output logic [REG_W-1:0] reg_b_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop, wr_en;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic [IDX_W-1:0]  rd_idx;

  i2c_bus_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slave_engine #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_eng (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .addr_sel_i, .tx_byte_i(rd_byte), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_byte_o(wr_byte), .sda_oe_o
  );

  cfg_reg_bank #(.REG_W(REG_W), .IN_W(IN_W), .RST_A(RST_A), .RST_B(RST_B)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_byte_i(wr_byte), .wp_i,
    .cap_i(start), .in_port_i, .rd_idx_i(rd_idx),
    .reg_a_o, .reg_b_o, .rd_byte_o(rd_byte)
  );
endmodule

// File: tb/tb_i2c_cfg_slave.sv
`timescale 1ns/1ps
module tb_i2c_cfg_slave;
  localparam int Q = 20;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1, asel = 1, wp = 0;
  logic [4:0] in_port = '0;
  logic sda_oe;
  logic [5:0] reg_a, reg_b;
  logic sda_bus;

  int n_tests = 0, n_fail = 0;
  bit done = 0, in_mbit = 0, cmp_en = 0;
  logic [5:0] exp_a = '0, exp_b = '0;
  string cur_tag = "R5";

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_cfg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(asel), .wp_i(wp), .in_port_i(in_port), .reg_a_o(reg_a), .reg_b_o(reg_b)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock reference compare
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (in_mbit) chk(sda_oe == 1'b0, "R1 slave quiet", int'(sda_oe), 0);
      if (cmp_en) begin
        chk(reg_a == exp_a, {cur_tag, " reg_a"}, int'(reg_a), int'(exp_a));
        chk(reg_b == exp_b, {cur_tag, " reg_b"}, int'(reg_b), int'(exp_b));
      end
    end
  end

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start(input bit chg, input logic [4:0] nv);
    m_sda = 1; qw(); m_scl = 1; qw();
    m_sda = 0; if (chg) in_port = nv; qw();
    m_scl = 0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 0; qw(); m_scl = 1; qw(); m_sda = 1; qw();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; qw(); m_scl = 1; in_mbit = 1; qw(); qw(); in_mbit = 0; m_scl = 0; qw();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1; qw(); m_scl = 1; qw(); b = sda_bus; qw(); m_scl = 0; qw();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~mack);
  endtask

  task automatic do_addr(input logic [6:0] a, input logic rw, input bit exp_ack, input string tag);
    logic ack;
    put_byte({a, rw}, ack);
    chk(ack == exp_ack, {tag, " address ack"}, int'(ack), int'(exp_ack));
  endtask

  task automatic do_write(input logic [7:0] d, input bit upd, input string tag);
    logic ack;
    cur_tag = tag;
    if (upd) cmp_en = 0;
    put_byte(d, ack);
    chk(ack == 1'b1, {tag, " data ack"}, int'(ack), 1);
    if (upd && d[7:6] == 2'b00) exp_a = d[5:0];
    if (upd && d[7:6] == 2'b01) exp_b = d[5:0];
    cmp_en = 1;
  endtask

  task automatic do_read(input logic [7:0] e, input bit mack, input string tag);
    logic [7:0] d;
    get_byte(d, mack);
    chk(d == e, {tag, " read byte"}, int'(d), int'(e));
  endtask

  initial begin
    logic b;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // reset state (R5)
    chk(sda_oe == 0, "R5 reset sda", int'(sda_oe), 0);
    chk(reg_a == 0, "R5 reset a", int'(reg_a), 0);
    chk(reg_b == 0, "R5 reset b", int'(reg_b), 0);
    cmp_en = 1;

    // R5 writes via high address
    asel = 1;
    bus_start(0, '0); do_addr(7'b1001110, 0, 1, "R2"); do_write(8'h2D, 1, "R5"); bus_stop();
    bus_start(0, '0); do_addr(7'b1001110, 0, 1, "R2"); do_write(8'h53, 1, "R5"); bus_stop();

    // R2 strap low: old address refused, other accepted
    asel = 0;
    bus_start(0, '0); do_addr(7'b1001110, 0, 0, "R2"); bus_stop();
    bus_start(0, '0); do_addr(7'b0110111, 0, 1, "R2"); do_write(8'h78, 1, "R5"); bus_stop();

    // R3 general call refused, following byte ignored
    bus_start(0, '0); do_addr(7'b0000000, 0, 0, "R3");
    begin
      logic ack;
      cur_tag = "R3";
      put_byte(8'h00, ack);
      chk(ack == 0, "R3 byte after gcall", int'(ack), 0);
    end
    bus_stop();

    // R4/R6/R12/R11 read sequence with snapshot held after START
    in_port = 5'h15;
    bus_start(0, '0); do_addr(7'b0110111, 1, 1, "R4");
    in_port = 5'h0A;
    cur_tag = "R8";
    do_read({2'b00, exp_a}, 1, "R4");
    do_read({2'b00, exp_b}, 1, "R4");
    do_read(8'h15, 1, "R6");
    do_read({2'b00, exp_a}, 0, "R12");
    get_bit(b);
    chk(b == 1'b1, "R11 released after nack", int'(b), 1);
    chk(sda_oe == 0, "R11 sda_oe idle", int'(sda_oe), 0);
    bus_stop();

    // R8 short read then full read again
    bus_start(0, '0); do_addr(7'b0110111, 1, 1, "R8"); do_read({2'b00, exp_a}, 0, "R8"); bus_stop();
    bus_start(0, '0); do_addr(7'b0110111, 1, 1, "R8");
    do_read({2'b00, exp_a}, 1, "R8"); do_read({2'b00, exp_b}, 0, "R8"); bus_stop();

    // R7 repeated START from read into write
    bus_start(0, '0); do_addr(7'b0110111, 1, 1, "R7"); do_read({2'b00, exp_a}, 0, "R7");
    bus_start(0, '0); do_addr(7'b0110111, 0, 1, "R7"); do_write(8'h07, 1, "R7"); bus_stop();
    chk(reg_a == 6'h07, "R7 reg_a after rs write", int'(reg_a), 7);

    // R9 write protect
    wp = 1;
    bus_start(0, '0); do_addr(7'b0110111, 0, 1, "R9"); do_write(8'h3F, 0, "R9"); bus_stop();
    bus_start(0, '0); do_addr(7'b0110111, 0, 1, "R9"); do_write(8'h6A, 0, "R9"); bus_stop();
    wp = 0;
    chk(reg_a == exp_a, "R9 reg_a held", int'(reg_a), int'(exp_a));

    // R10 select 1x ignored
    bus_start(0, '0); do_addr(7'b0110111, 0, 1, "R10"); do_write(8'hAA, 0, "R10"); bus_stop();
    bus_start(0, '0); do_addr(7'b0110111, 0, 1, "R10"); do_write(8'hC5, 0, "R10"); bus_stop();
    chk(reg_b == exp_b, "R10 reg_b held", int'(reg_b), int'(exp_b));

    // R1 STOP mid-address aborts, next transaction works
    bus_start(0, '0);
    put_bit(0); put_bit(1); put_bit(1); put_bit(0);
    bus_stop();
    chk(sda_oe == 0, "R1 abort released", int'(sda_oe), 0);
    bus_start(0, '0); do_addr(7'b0110111, 0, 1, "R1"); do_write(8'h41, 1, "R1"); bus_stop();
    chk(reg_b == 6'h01, "R1 write after abort", int'(reg_b), 1);

    // R6 input change coinciding with START is captured, later change is not
    bus_start(1, 5'h1C); do_addr(7'b0110111, 1, 1, "R6");
    in_port = 5'h03;
    do_read({2'b00, exp_a}, 1, "R6"); do_read({2'b00, exp_b}, 1, "R6");
    do_read(8'h1C, 0, "R6");
    bus_stop();

    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule